// File: doc/BRIEF.md
# Power-Management Companion Register Bridge

This block lets a host processor reach the 16-bit registers of a companion power-management chip through a narrow serial link. On the host side it shows a small memory-mapped register port and a write window. A store into the window is queued in a FIFO and sent out as a serial write frame. A read starts when the host stores a register offset into the command register. The host then polls a combined result register. This register carries a busy flag, the returned data and an echo of the accessed address, so software can confirm which register answered.

The serial side is a half-duplex shift link with a clock, an active-low select, a data-out and a data-in line. One frame is a direction bit (1 = read, 0 = write), the slave byte offset sent MSB first, and then 16 data bits: the bridge drives them for a write and samples them for a read. The bridge changes its outputs while the serial clock is low. The slave samples on the rising serial clock and updates its data-in bit on the falling serial clock. The parameter `ADDR_MODE` selects one of three geometries:
- mode 0: 4 KiB, one slave, window at 0x8000.
- mode 1: 16 KiB, window at 0x8000, three slaves selected by offset bits 13:12.
- mode 2 (the default): 128 KiB, window at 0x20000, three slaves selected by offset bits 16:15.

Top module: `pmic_bridge`

## Requirements
- R1: A host store to the command register (offset 0x0) starts a serial read frame with no further action. The frame has direction bit 1, then the 17-bit offset MSB first, then 16 data bits during which the bridge drives 0.
- R2: Bit 31 of the result register (offset 0x4) reads 1 when it is read in the cycle right after an accepted command store. It reads 0 again once the read frame has completed.
- R3: After a read completes, result bits 15:0 hold the 16 bits returned by the slave. Bits 30:16 hold the offset's bits 16:2 in mode 2 (bits 14:0 in modes 0 and 1).
- R4: The FIFO status register (offset 0x8) shows the write FIFO full on bit 11 and empty on bit 10. All other bits read 0.
- R5: A host store to window address 0x20000 + off pushes (off, data[15:0]) into the write FIFO. It is sent as a frame with direction bit 0, the 17-bit offset, then the 16 data bits, in the order of the stores.
- R6: An offset of 0x20000 or more, or an offset whose slave-select bits 16:15 equal 3, is refused, whether it arrives as a command or as a window store. A refused offset sets error-status bit 0 (offset 0xC) and produces no serial frame and no busy flag.
- R7: A read command issued while window writes are still queued waits until every queued write has been sent. A read of a just-written register therefore returns the last value written.
- R8: A window store that finds the FIFO full is dropped, never reaches the slave, and sets error-status bit 1.
- R9: Writing 1 to an error-status bit clears it. Writing 0 leaves it set.
- R10: After reset the result register reads 0, the FIFO status reads 0x400, the error status reads 0, and the serial select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host store strobe |
| hst_rd | input | 1 | Host load strobe; data appears on hst_rdata after the next edge |
| hst_addr | input | HAW | Host byte address (registers and write window) |
| hst_wdata | input | 32 | Host store data |
| hst_rdata | output | 32 | Registered host load data |
| ser_sck | output | 1 | Serial clock, idles low |
| ser_cs_n | output | 1 | Serial select, active low |
| ser_mosi | output | 1 | Serial data to the slave |
| ser_miso | input | 1 | Serial data from the slave |

## Verification
The host can push a window store into the FIFO in the same cycle that the serial engine pops the FIFO head to start a frame. Six stores are therefore issued back to back on consecutive cycles while the engine is idle. The first store is popped at once, so the second store lands in the same cycle as that pop. The FIFO then fills, and only the sixth store finds it full. The bench scoreboard expects exactly five write frames in store order and error-status bit 1 set. It also reads back the sixth offset through a serial read, which must return the slave's untouched value.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;

  localparam logic [31:0] PMB_REG_CMD   = 32'h0;
  localparam logic [31:0] PMB_REG_RDATA = 32'h4;
  localparam logic [31:0] PMB_REG_FSTS  = 32'h8;
  localparam logic [31:0] PMB_REG_ERR   = 32'hC;

  typedef enum logic [1:0] {SH_IDLE, SH_SHIFT, SH_END} sh_state_t;

  // slave address space in bytes for each geometry
  function automatic int pmb_space(input int mode);
    case (mode)
      0:       return 32'h1000;
      1:       return 32'h4000;
      default: return 32'h20000;
    endcase
  endfunction

  // host offset where the write window begins
  function automatic int pmb_win(input int mode);
    return (mode == 2) ? 32'h20000 : 32'h8000;
  endfunction

  // number of slave offset bits carried in a frame
  function automatic int pmb_aw(input int mode);
    case (mode)
      0:       return 12;
      1:       return 14;
      default: return 17;
    endcase
  endfunction

endpackage

// File: rtl/pmic_bridge_fifo.sv
module pmic_bridge_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign dout  = mem[rptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/pmic_bridge_shifter.sv
module pmic_bridge_shifter
  import pmic_bridge_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_rd,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic          busy,
  output logic          done,
  output logic          done_rd,
  output logic [15:0]   rdata,
  output logic          sck,
  output logic          cs_n,
  output logic          mosi,
  input  logic          miso
);
  localparam int FW = 1 + AW + 16;
  localparam int CW = $clog2(FW + 1);

  sh_state_t     state;
  logic [FW-1:0] shreg;
  logic [CW-1:0] cnt;
  logic          phase;
  logic          op_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SH_IDLE;
      shreg <= '0;
      cnt   <= '0;
      phase <= 1'b0;
      op_rd <= 1'b0;
      sck   <= 1'b0;
      cs_n  <= 1'b1;
      mosi  <= 1'b0;
    end else begin
      case (state)
        SH_IDLE: begin
          if (start) begin
            shreg <= {is_rd, addr, (is_rd ? 16'h0 : wdata)};
            op_rd <= is_rd;
            mosi  <= is_rd;
            cs_n  <= 1'b0;
            sck   <= 1'b0;
            phase <= 1'b0;
            cnt   <= '0;
            state <= SH_SHIFT;
          end
        end
        SH_SHIFT: begin
          if (!phase) begin
            sck   <= 1'b1;
            phase <= 1'b1;
          end else begin
            sck   <= 1'b0;
            phase <= 1'b0;
            shreg <= {shreg[FW-2:0], miso};
            mosi  <= shreg[FW-2];
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(FW - 1)) begin
              cs_n  <= 1'b1;
              mosi  <= 1'b0;
              state <= SH_END;
            end
          end
        end
        SH_END:  state <= SH_IDLE;
        default: state <= SH_IDLE;
      endcase
    end
  end

  assign busy    = (state != SH_IDLE);
  assign done    = (state == SH_END);
  assign done_rd = done && op_rd;
  assign rdata   = shreg[15:0];

endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
  import pmic_bridge_pkg::*;
#(
  parameter int ADDR_MODE  = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int HAW        = 18
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hst_wr,
  input  logic           hst_rd,
  input  logic [HAW-1:0] hst_addr,
  input  logic [31:0]    hst_wdata,
  output logic [31:0]    hst_rdata,
  output logic           ser_sck,
  output logic           ser_cs_n,
  output logic           ser_mosi,
  input  logic           ser_miso
);
  localparam int SPACE = pmb_space(ADDR_MODE);
  localparam int WIN   = pmb_win(ADDR_MODE);
  localparam int AW    = pmb_aw(ADDR_MODE);
  localparam int EW    = AW + 16;

  // refused offsets: outside the space, or the unused fourth slave select
  function automatic logic off_bad(input logic [31:0] o);
    logic b;
    b = (o >= 32'(SPACE));
    if (ADDR_MODE != 0 && o[AW-1 -: 2] == 2'b11) b = 1'b1;
    return b;
  endfunction

  logic [31:0]   haddr32;
  logic          cmd_wr, win_wr, cmd_bad, win_bad, cmd_go;
  logic [31:0]   woff32;
  logic [14:0]   cmd_echo;

  logic          busy_q, rd_pend_q, err_q, ovf_q;
  logic [AW-1:0] rd_off_q;
  logic [14:0]   echo_q;
  logic [15:0]   rdat_q;

  logic          fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [EW-1:0] fifo_q;
  logic          sh_busy, sh_done, sh_done_rd, sh_start, start_wr, start_rd;
  logic [15:0]   sh_rdata;
  logic [AW-1:0] sh_addr;

  assign haddr32 = 32'(hst_addr);
  assign cmd_wr  = hst_wr && (haddr32 == PMB_REG_CMD);
  assign win_wr  = hst_wr && (haddr32 >= 32'(WIN)) && (haddr32 < 32'(WIN + SPACE));
  assign woff32  = haddr32 - 32'(WIN);
  assign cmd_bad = off_bad(hst_wdata);
  assign win_bad = off_bad(woff32);
  assign cmd_go  = cmd_wr && !busy_q && !cmd_bad;

  // echoed address field depends on the geometry
  generate
    if (ADDR_MODE == 2) begin : g_echo_word
      assign cmd_echo = hst_wdata[16:2];
    end else begin : g_echo_byte
      assign cmd_echo = hst_wdata[14:0];
    end
  endgenerate

  // queued writes always go first, so a read sees every earlier store
  assign start_wr  = !sh_busy && !fifo_empty;
  assign start_rd  = !sh_busy && fifo_empty && rd_pend_q;
  assign sh_start  = start_wr || start_rd;
  assign sh_addr   = start_wr ? fifo_q[EW-1:16] : rd_off_q;
  assign fifo_pop  = start_wr;
  assign fifo_push = win_wr && !win_bad && !fifo_full;

  pmic_bridge_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .din   ({woff32[AW-1:0], hst_wdata[15:0]}),
    .pop   (fifo_pop),
    .dout  (fifo_q),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  pmic_bridge_shifter #(.AW(AW)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (sh_start),
    .is_rd   (!start_wr),
    .addr    (sh_addr),
    .wdata   (fifo_q[15:0]),
    .busy    (sh_busy),
    .done    (sh_done),
    .done_rd (sh_done_rd),
    .rdata   (sh_rdata),
    .sck     (ser_sck),
    .cs_n    (ser_cs_n),
    .mosi    (ser_mosi),
    .miso    (ser_miso)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_off_q  <= '0;
      echo_q    <= '0;
      rdat_q    <= '0;
      err_q     <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (cmd_go) begin
        busy_q    <= 1'b1;
        rd_pend_q <= 1'b1;
        rd_off_q  <= hst_wdata[AW-1:0];
        echo_q    <= cmd_echo;
      end
      if (start_rd) rd_pend_q <= 1'b0;
      if (sh_done_rd) begin
        busy_q <= 1'b0;
        rdat_q <= sh_rdata;
      end
      if (hst_wr && haddr32 == PMB_REG_ERR) begin
        err_q <= err_q & ~hst_wdata[0];
        ovf_q <= ovf_q & ~hst_wdata[1];
      end
      if ((cmd_wr && !busy_q && cmd_bad) || (win_wr && win_bad)) err_q <= 1'b1;
      if (win_wr && !win_bad && fifo_full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata <= '0;
    end else if (hst_rd) begin
      case (haddr32)
        PMB_REG_RDATA: hst_rdata <= {busy_q, echo_q, rdat_q};
        PMB_REG_FSTS:  hst_rdata <= {20'b0, fifo_full, fifo_empty, 10'b0};
        PMB_REG_ERR:   hst_rdata <= {30'b0, ovf_q, err_q};
        default:       hst_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/pmic_bridge_chk.sv
module pmic_bridge_chk
  import pmic_bridge_pkg::*;
#(
  parameter int ADDR_MODE = 2,
  parameter int HAW       = 18
) (
  input logic           clk,
  input logic           rst,
  input logic           hst_wr,
  input logic [HAW-1:0] hst_addr,
  input logic [31:0]    hst_wdata,
  input logic           ser_cs_n,
  input logic           busy_q,
  input logic           fifo_full,
  input logic           fifo_empty,
  input logic           ovf_q,
  input logic           sh_busy
);
  localparam int SPACE = pmb_space(ADDR_MODE);
  localparam int WIN   = pmb_win(ADDR_MODE);
  localparam int AW    = pmb_aw(ADDR_MODE);

  function automatic logic sel_bad(input logic [31:0] o);
    return (ADDR_MODE != 0) && (o[AW-1 -: 2] == 2'b11);
  endfunction

  logic [31:0] a32, woff;
  logic        cmd_ok, cmd_far, win_ok;
  assign a32     = 32'(hst_addr);
  assign woff    = a32 - 32'(WIN);
  assign cmd_ok  = hst_wr && a32 == PMB_REG_CMD && hst_wdata < 32'(SPACE) && !sel_bad(hst_wdata);
  assign cmd_far = hst_wr && a32 == PMB_REG_CMD && hst_wdata >= 32'(SPACE);
  assign win_ok  = hst_wr && a32 >= 32'(WIN) && a32 < 32'(WIN + SPACE) && !sel_bad(woff);

  // R2: an accepted command raises busy at the next edge
  p_busy_set_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_ok && !busy_q) |=> busy_q);

  // R3: busy only falls after the frame has ended
  p_busy_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> ser_cs_n);

  // R4: the two FIFO flags are never both set
  p_flags_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_full, fifo_empty}));

  // R6: a refused command leaves the link and busy untouched
  p_range_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_far && !busy_q && fifo_empty && !sh_busy) |=> (ser_cs_n && !busy_q));

  // R8: a store into a full FIFO latches overflow
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (win_ok && fifo_full) |=> ovf_q);

  // R1: select is low only while the engine runs
  p_cs_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !sh_busy |-> ser_cs_n);

endmodule

bind pmic_bridge pmic_bridge_chk #(.ADDR_MODE(ADDR_MODE), .HAW(HAW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hst_wr     (hst_wr),
  .hst_addr   (hst_addr),
  .hst_wdata  (hst_wdata),
  .ser_cs_n   (ser_cs_n),
  .busy_q     (busy_q),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .ovf_q      (ovf_q),
  .sh_busy    (sh_busy)
);

// File: tb/test_pmic_bridge.sv
module test_pmic_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 17;
  localparam int FW  = 1 + AW + 16;
  localparam int WIN = 32'h20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_wr = 1'b0, hst_rd = 1'b0;
  logic [17:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        ser_sck, ser_cs_n, ser_mosi;
  logic        ser_miso = 1'b0;

  int checks = 0, failures = 0, frames = 0;
  logic [FW-1:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmic_bridge i_pmic_bridge (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ser_sck(ser_sck),
    .ser_cs_n(ser_cs_n), .ser_mosi(ser_mosi), .ser_miso(ser_miso)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural slave register file
  logic [15:0] smem [logic [16:0]];
  logic [FW-1:0] sbits = '0;
  int scnt = 0;
  logic [15:0] rdv = '0;

  function automatic logic [15:0] sval(input logic [16:0] a);
    if (smem.exists(a)) return smem[a];
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // shift-in and frame monitor (scoreboard pop and compare)
  always @(posedge ser_sck or posedge ser_cs_n) begin
    if (ser_cs_n) begin
      if (scnt == FW) begin
        frames++;
        if (sbits[FW-1] == 1'b0) smem[sbits[FW-2:16]] = sbits[15:0];
        if (expq.size() == 0) begin
          chk(1'b0, "R5 unexpected frame", 32'(sbits), 32'h0);
        end else begin
          logic [FW-1:0] e;
          e = expq.pop_front();
          checks++;
          if (e !== sbits) begin
            failures++;
            $display("FAIL R1/R5 frame actual=%h expected=%h", sbits, e);
          end
        end
      end
      scnt <= 0;
    end else begin
      sbits <= {sbits[FW-2:0], ser_mosi};
      scnt  <= scnt + 1;
    end
  end

  always @(negedge ser_sck) begin
    if (!ser_cs_n) begin
      if (scnt == AW + 1) begin
        rdv = sval(sbits[AW-1:0]);
        ser_miso <= rdv[15];
      end else if (scnt > AW + 1 && scnt < FW) begin
        ser_miso <= rdv[15 - (scnt - AW - 1)];
      end
    end
  end

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_addr = a[17:0]; hst_wdata = d;
    @(posedge clk); #1;
    hst_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    hst_rd = 1'b1; hst_addr = a[17:0];
    @(posedge clk); #1;
    hst_rd = 1'b0;
    d = hst_rdata;
  endtask

  task automatic win_wr(input logic [16:0] off, input logic [15:0] d);
    expq.push_back({1'b0, off, d});
    bus_wr(WIN + 32'(off), {16'h0, d});
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      if (expq.size() == 0 && ser_cs_n) break;
      @(posedge clk);
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic do_read(input logic [16:0] off, output logic [31:0] rv);
    expq.push_back({1'b1, off, 16'h0});
    bus_wr(32'h0, 32'(off));
    for (int i = 0; i < 1000; i++) begin
      bus_rd(32'h4, rv);
      if (!rv[31]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int f0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10 reset state
    bus_rd(32'h4, rv); chk(rv == 32'h0, "R10 result", rv, 32'h0);
    bus_rd(32'h8, rv); chk(rv == 32'h400, "R10 fifo status", rv, 32'h400);
    bus_rd(32'hC, rv); chk(rv == 32'h0, "R10 error status", rv, 32'h0);
    chk(ser_cs_n == 1'b1, "R10 select idle", 32'(ser_cs_n), 32'h1);

    // R5 single window write, R4 not-empty then empty
    win_wr(17'h0104, 16'hBEEF);
    bus_rd(32'h8, rv); chk(rv == 32'h0, "R4 not empty", rv, 32'h0);
    drain();
    bus_rd(32'h8, rv); chk(rv == 32'h400, "R4 empty after drain", rv, 32'h400);

    // R1 R2 R3 read of a written register
    expq.push_back({1'b1, 17'h0104, 16'h0});
    bus_wr(32'h0, 32'h0104);
    bus_rd(32'h4, rv); chk(rv[31] == 1'b1, "R2 busy after command", 32'(rv[31]), 32'h1);
    for (int i = 0; i < 1000; i++) begin
      bus_rd(32'h4, rv);
      if (!rv[31]) break;
    end
    chk(rv[31] == 1'b0, "R2 busy cleared", 32'(rv[31]), 32'h0);
    chk(rv[15:0] == 16'hBEEF, "R3 data", 32'(rv[15:0]), 32'hBEEF);
    chk(rv[30:16] == 15'h41, "R3 echo", 32'(rv[30:16]), 32'h41);

    // R3 unwritten register returns slave default
    do_read(17'h1F00, rv);
    chk(rv[15:0] == (16'h1F00 ^ 16'h5A3C), "R3 default data", 32'(rv[15:0]), 32'(16'h1F00 ^ 16'h5A3C));
    chk(rv[30:16] == 15'h7C0, "R3 echo 2", 32'(rv[30:16]), 32'h7C0);

    // R7 read waits for queued writes
    win_wr(17'h0200, 16'h1111);
    win_wr(17'h0200, 16'h2222);
    win_wr(17'h0200, 16'h3333);
    do_read(17'h0200, rv);
    chk(rv[15:0] == 16'h3333, "R7 ordering", 32'(rv[15:0]), 32'h3333);
    drain();

    // R8 R4 overflow with six back-to-back stores (push and pop coincide)
    for (int i = 0; i < 5; i++) win_wr(17'h0300 + 17'(4 * i), 16'hA000 + 16'(i));
    bus_wr(WIN + 32'h0314, 32'hA005);
    bus_rd(32'h8, rv); chk(rv == 32'h800, "R4 full", rv, 32'h800);
    bus_rd(32'hC, rv); chk(rv[1] == 1'b1, "R8 overflow flag", 32'(rv[1]), 32'h1);
    drain();
    do_read(17'h0314, rv);
    chk(rv[15:0] == (16'h0314 ^ 16'h5A3C), "R8 dropped store", 32'(rv[15:0]), 32'(16'h0314 ^ 16'h5A3C));
    drain();

    // R9 write-one-to-clear
    bus_wr(32'hC, 32'h0);
    bus_rd(32'hC, rv); chk(rv[1] == 1'b1, "R9 zero keeps", 32'(rv[1]), 32'h1);
    bus_wr(32'hC, 32'h2);
    bus_rd(32'hC, rv); chk(rv == 32'h0, "R9 clear", rv, 32'h0);

    // R6 refused offsets
    f0 = frames;
    bus_wr(32'h0, 32'h20000);
    bus_rd(32'h4, rv); chk(rv[31] == 1'b0, "R6 no busy", 32'(rv[31]), 32'h0);
    bus_rd(32'hC, rv); chk(rv[0] == 1'b1, "R6 range error", 32'(rv[0]), 32'h1);
    bus_wr(32'hC, 32'h1);
    bus_wr(32'h0, 32'h18000);
    bus_rd(32'hC, rv); chk(rv[0] == 1'b1, "R6 select 3 error", 32'(rv[0]), 32'h1);
    bus_wr(32'hC, 32'h1);
    bus_wr(WIN + 32'h18004, 32'h5555);
    bus_rd(32'hC, rv); chk(rv[0] == 1'b1, "R6 window select 3", 32'(rv[0]), 32'h1);
    bus_rd(32'h8, rv); chk(rv == 32'h400, "R6 nothing queued", rv, 32'h400);
    repeat (200) @(posedge clk);
    chk(frames == f0, "R6 no frame", 32'(frames), 32'(f0));
    chk(expq.size() == 0, "R1 all frames seen", 32'(expq.size()), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule